// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Bridge

This block carries one multi-bit word at a time from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. Upstream logic offers a word with a valid/ready pair. The sender copies the word into a holding register in the source domain and then raises a request line. The receiver sees the request through a two-flop synchronizer and copies the held bus into its own output register. It offers the word downstream with a second valid/ready pair. The receiver answers with an acknowledge only after downstream has taken the word. The acknowledge crosses back through its own two-flop synchronizer.

The exchange returns to zero. The request rises, the acknowledge rises, the request falls, and then the acknowledge falls. Only after that does the sender take another word. Because the request is at rest when it is low, a reset of the source side alone leaves the line idle and cannot start a transfer. Each domain has its own active-low asynchronous reset. Backpressure on either side simply stretches the exchange.

Top module: `fourPhaseCdcBridge`

## Requirements
- R1: After both resets are released, `dstValid` is low, no word is delivered, and `srcReady` is high.
- R2: A word is accepted on a `srcClk` edge where `srcValid` and `srcReady` are both high. From the next cycle, `srcReady` stays low until the acknowledge has been seen high and then low again.
- R3: The delivered word is the value on `srcData` at the accepting edge. Changes on `srcData` while the transfer is in flight have no effect on it.
- R4: The request rises only after an accepting edge and stays high until the synchronized acknowledge is high. So `srcReady` returns high only after the word has been handed downstream.
- R5: While `dstValid` is high and `dstReady` is low, `dstValid` stays high and `dstData` stays unchanged on the next `dstClk` edge.
- R6: The acknowledge rises on the `dstClk` edge that completes a downstream handshake, and `dstValid` is low in the cycle after that edge. The acknowledge falls once the synchronized request is low. No new word is taken until the request rises again.
- R7: Every accepted word reaches the output exactly once and in order. This holds when either clock is the faster one and under random backpressure on both sides.
- R8: Resetting only the source side while it is idle delivers no word at the destination, and later transfers work normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| srcValid | input | 1 | Upstream offers a word |
| srcReady | output | 1 | Sender can accept a word |
| srcData | input | DATA_W | Word offered by upstream |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| dstValid | output | 1 | Word available downstream |
| dstReady | input | 1 | Downstream takes the word |
| dstData | output | DATA_W | Word presented downstream |

## Verification
Each side's handshake is decided by values that are already settled at the falling edge before the rising edge that acts on them. So the bench drives and samples at falling edges. It treats a handshake as taking effect on the very next rising edge. One source cycle after an accepting edge, `srcReady` is due low. One destination cycle after a downstream handshake, `dstValid` is due low. During a stall, the output word is due unchanged in the following cycle. The arrival time of a word depends on synchronizer delay and on the ratio of the two clocks. So the checks on delivery depend only on order, word values and counts, and never on a fixed latency. A return of `srcReady` is checked against the number of words already delivered.

// File: rtl/fpcbPkg.sv
package fpcbPkg;

  // Strobes from the two control FSMs to the datapath
  typedef struct packed {
    logic srcLoad;   // capture upstream word into the holding register
    logic dstLoad;   // copy holding register into the output register
  } strobe_t;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_DROP = 2'd2
  } srcState_t;

  typedef enum logic [1:0] {
    DST_IDLE = 2'd0,
    DST_HOLD = 2'd1,
    DST_ACK  = 2'd2
  } dstState_t;

endpackage

// File: rtl/fpcbSync.sv
module fpcbSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/fpcbSrcCtrl.sv
module fpcbSrcCtrl
  import fpcbPkg::*;
(
  input  logic srcClk,
  input  logic srcRstN,
  input  logic srcValid,
  output logic srcReady,
  input  logic ackSync,
  output logic req,
  output logic srcLoad
);

  srcState_t state;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      state <= SRC_IDLE;
      req   <= 1'b0;
    end else begin
      case (state)
        SRC_IDLE: if (srcValid && srcReady) begin
          state <= SRC_REQ;
          req   <= 1'b1;
        end
        SRC_REQ: if (ackSync) begin
          state <= SRC_DROP;
          req   <= 1'b0;
        end
        SRC_DROP: if (!ackSync) state <= SRC_IDLE;
        default: begin
          state <= SRC_IDLE;
          req   <= 1'b0;
        end
      endcase
    end
  end

  assign srcReady = (state == SRC_IDLE) && !ackSync;
  assign srcLoad  = srcValid && srcReady;

  AST_REQ_FROM_ACCEPT: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $rose(req) |-> $past(srcValid && srcReady)); // R4
  AST_REQ_HELD: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (req && !ackSync) |=> req); // R4
  AST_REQ_RELEASED: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (req && ackSync) |=> !req); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (srcValid && srcReady) |=> !srcReady); // R2
  AST_NOT_READY_WHILE_REQ: assert property (@(posedge srcClk) disable iff (!srcRstN)
    req |-> !srcReady); // R2

endmodule

// File: rtl/fpcbDstCtrl.sv
module fpcbDstCtrl
  import fpcbPkg::*;
(
  input  logic dstClk,
  input  logic dstRstN,
  input  logic reqSync,
  output logic dstValid,
  input  logic dstReady,
  output logic ack,
  output logic dstLoad
);

  dstState_t state;

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      state    <= DST_IDLE;
      dstValid <= 1'b0;
      ack      <= 1'b0;
    end else begin
      case (state)
        DST_IDLE: if (reqSync) begin
          state    <= DST_HOLD;
          dstValid <= 1'b1;
        end
        DST_HOLD: if (dstReady) begin
          state    <= DST_ACK;
          dstValid <= 1'b0;
          ack      <= 1'b1;
        end
        DST_ACK: if (!reqSync) begin
          state <= DST_IDLE;
          ack   <= 1'b0;
        end
        default: begin
          state    <= DST_IDLE;
          dstValid <= 1'b0;
          ack      <= 1'b0;
        end
      endcase
    end
  end

  assign dstLoad = (state == DST_IDLE) && reqSync;

  AST_VALID_HELD: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstValid && !dstReady) |=> dstValid); // R5
  AST_ACK_ON_TAKE: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstValid && dstReady) |=> (ack && !dstValid)); // R6
  AST_ACK_KEPT: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (ack && reqSync) |=> ack); // R6
  AST_ACK_RETURNS: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (ack && !reqSync) |=> !ack); // R6
  AST_NO_VALID_WITH_ACK: assert property (@(posedge dstClk) disable iff (!dstRstN)
    ack |-> !dstValid); // R7

endmodule

// File: rtl/fpcbDatapath.sv
module fpcbDatapath
  import fpcbPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              dstClk,
  input  logic              dstRstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] dstData
);

  logic [DATA_W-1:0] holdReg;

  // Source-side register: the only thing that drives the crossing bus
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)            holdReg <= '0;
    else if (strobes.srcLoad) holdReg <= srcData;
  end

  // Destination capture, enabled only once the synchronized request is high
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN)             dstData <= '0;
    else if (strobes.dstLoad) dstData <= holdReg;
  end

endmodule

// File: rtl/fourPhaseCdcBridge.sv
module fourPhaseCdcBridge
  import fpcbPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [DATA_W-1:0] srcData,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic              dstValid,
  input  logic              dstReady,
  output logic [DATA_W-1:0] dstData
);

  logic    req, ack, reqSync, ackSync;
  logic    srcLoadW, dstLoadW;
  strobe_t strobes;

  assign strobes = '{srcLoad: srcLoadW, dstLoad: dstLoadW};

  fpcbSync #(.STAGES(SYNC_STAGES)) uReqSync (
    .clk(dstClk), .rstN(dstRstN), .din(req), .dout(reqSync));

  fpcbSync #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk(srcClk), .rstN(srcRstN), .din(ack), .dout(ackSync));

  fpcbSrcCtrl uSrcCtrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcValid(srcValid),
    .srcReady(srcReady), .ackSync(ackSync), .req(req), .srcLoad(srcLoadW));

  fpcbDstCtrl uDstCtrl (
    .dstClk(dstClk), .dstRstN(dstRstN), .reqSync(reqSync),
    .dstValid(dstValid), .dstReady(dstReady), .ack(ack), .dstLoad(dstLoadW));

  fpcbDatapath #(.DATA_W(DATA_W)) uDatapath (
    .srcClk(srcClk), .srcRstN(srcRstN), .dstClk(dstClk), .dstRstN(dstRstN),
    .strobes(strobes), .srcData(srcData), .dstData(dstData));

  AST_DATA_STABLE: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstValid && !dstReady) |=> $stable(dstData)); // R5
  AST_LOAD_ONLY_IDLE: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstLoadW |-> !dstValid); // R6

endmodule

// File: tb/fourPhaseCdcBridge_test.sv
`timescale 1ns/1ps
module fourPhaseCdcBridge_test;

  localparam int W = 16;

  logic          srcClk = 1'b0, dstClk = 1'b0;
  logic          srcRstN = 1'b0, dstRstN = 1'b0;
  logic          srcValid = 1'b0, dstReady = 1'b0;
  logic [W-1:0]  srcData = '0;
  logic          srcReady, dstValid;
  logic [W-1:0]  dstData;
  real           dstHalf = 3.5;

  int checks = 0, fails = 0;
  int txCount = 0, rxCount = 0, txTarget = 0;
  int validPct = 60, readyPct = 30;
  bit streamOn = 1'b0, quietWindow = 1'b0, quietSeen = 1'b0;

  always #2 srcClk = ~srcClk;          // 250 MHz
  always #(dstHalf) dstClk = ~dstClk;

  fourPhaseCdcBridge #(.DATA_W(W)) uut (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcValid(srcValid), .srcReady(srcReady),
    .srcData(srcData), .dstClk(dstClk), .dstRstN(dstRstN), .dstValid(dstValid),
    .dstReady(dstReady), .dstData(dstData));

  function automatic logic [W-1:0] wordOf(input int i);
    logic [31:0] t;
    t = 32'(i) * 32'h0000_9E37 + 32'h0000_5A5A;
    return t[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Source-side driver, falling edges of srcClk
  initial begin
    bit busy = 1'b0;
    bit justAccepted = 1'b0;
    forever begin
      @(negedge srcClk);
      if (!srcRstN) begin
        busy = 1'b0; justAccepted = 1'b0; srcValid = 1'b0;
      end else begin
        if (justAccepted) chk(!srcReady, "R2 ready low after accept", srcReady, 0);
        justAccepted = 1'b0;
        if (busy && srcReady) begin
          busy = 1'b0;
          chk(rxCount >= txCount, "R4 ready returned before delivery", rxCount, txCount);
        end
        if (!busy && streamOn && txCount < txTarget && $urandom_range(99) < validPct) begin
          srcValid = 1'b1;
          srcData  = wordOf(txCount);
        end else begin
          srcValid = 1'b0;
          srcData  = W'($urandom);      // R3: junk while in flight
        end
        if (srcValid && srcReady) begin
          txCount++;
          busy = 1'b1;
          justAccepted = 1'b1;
        end
      end
    end
  end

  // Destination-side driver and monitor, falling edges of dstClk
  initial begin
    bit prevStall = 1'b0, prevFire = 1'b0;
    logic [W-1:0] prevData = '0;
    forever begin
      @(negedge dstClk);
      if (!dstRstN) begin
        prevStall = 1'b0; prevFire = 1'b0; dstReady = 1'b0;
      end else begin
        if (prevStall)
          chk(dstValid && dstData == prevData, "R5 stalled word changed", dstData, prevData);
        if (prevFire)
          chk(!dstValid, "R6 valid after downstream take", dstValid, 0);
        if (quietWindow && dstValid) quietSeen = 1'b1;
        dstReady  = ($urandom_range(99) < readyPct);
        prevStall = dstValid && !dstReady;
        prevFire  = dstValid && dstReady;
        prevData  = dstData;
        if (prevFire) begin
          chk(rxCount < txCount, "R7 extra word", rxCount, txCount);
          chk(dstData == wordOf(rxCount), "R7 R3 word value/order", dstData, wordOf(rxCount));
          rxCount++;
        end
      end
    end
  end

  task automatic runWords(input int n);
    txTarget += n;
    streamOn = 1'b1;
    wait (rxCount == txTarget);
    streamOn = 1'b0;
    repeat (20) @(posedge srcClk);
  endtask

  initial begin
    for (int phase = 0; phase < 2; phase++) begin
      dstHalf  = (phase == 0) ? 3.5 : 1.3;
      validPct = (phase == 0) ? 60 : 90;
      readyPct = (phase == 0) ? 30 : 75;
      srcRstN = 1'b0; dstRstN = 1'b0;
      repeat (5) @(posedge srcClk);
      srcRstN = 1'b1; dstRstN = 1'b1;
      repeat (10) @(negedge srcClk);
      chk(srcReady == 1'b1, "R1 srcReady after reset", srcReady, 1);
      chk(dstValid == 1'b0, "R1 dstValid after reset", dstValid, 0);
      chk(rxCount == txCount, "R1 no word after reset", rxCount, txCount);
      runWords(60);
      chk(rxCount == txCount, "R7 delivered count", rxCount, txCount);

      // R8: source-only reset while idle
      @(negedge srcClk);
      srcRstN = 1'b0;
      quietWindow = 1'b1; quietSeen = 1'b0;
      repeat (3) @(negedge srcClk);
      srcRstN = 1'b1;
      repeat (40) @(negedge dstClk);
      quietWindow = 1'b0;
      chk(!quietSeen, "R8 word after source reset", quietSeen, 0);
      chk(rxCount == txCount, "R8 count after source reset", rxCount, txCount);
      runWords(20);
      chk(rxCount == txTarget, "R8 R7 transfers after source reset", rxCount, txTarget);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge srcClk);
    checks++;
    fails++;
    $display("FAIL watchdog expired rx=%0d expected=%0d", rxCount, txTarget);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule